// File: doc/BRIEF.md
# Branch Prediction Eligibility Filter

This block sits between the instruction decoder and the branch predictor. Each cycle it may receive one record of pre-decoded attributes: the branch kind, whether the instruction writes the program counter, the current and next instruction-set state, the flag-setting suffix, a mode-change marker and membership in a conditional (if-then-else) block. One cycle later it reports whether the predictor may act on that instruction, and which class of branch it is.

The filter applies two kinds of rule. Inclusion rules make every branch eligible, whatever its addressing mode, and also any data-processing instruction that writes the program counter. Exclusion rules override the inclusion rules. They cover the flag-setting suffix, mode changes, and a change between any pair of instruction-set states other than the wide and narrow pair. In the narrow state, an unconditional encoding inside a conditional block is reclassified as a conditional branch. The class is reported even when prediction is refused, so the predictor can still keep statistics.

Top module: `bp_elig_filter`

## Requirements
- R1: Outputs are registered: `out_valid` equals `in_valid` from the previous cycle. A synchronous active-high `rst` clears `out_valid` and `out_predict` to 0 and `out_class` to 2'b00 on the next edge.
- R2: A record with `in_kind` conditional (2'b01), unconditional (2'b10) or indirect (2'b11) and no exclusion gives `out_predict`=1, and `out_class` equals `in_kind` (except under R8).
- R3: A record with `in_kind` none (2'b00) and `in_wr_pc`=1 is treated as an indirect branch: `out_class`=2'b11, and `out_predict`=1 unless excluded.
- R4: A switch from wide (2'b00) to narrow (2'b01) state, or from narrow to wide, as given by `in_isa_cur` and `in_isa_next`, does not block prediction. When the two fields are equal, no switch takes place.
- R5: A change between any other pair of states (the states being wide 2'b00, narrow 2'b01, extended 2'b10 and bytecode 2'b11) forces `out_predict`=0. The class is still reported.
- R6: `in_set_flags`=1 forces `out_predict`=0. The class is still reported.
- R7: `in_mode_chg`=1 forces `out_predict`=0. The class is still reported.
- R8: When `in_isa_cur` is narrow (2'b01), an unconditional record with `in_in_block`=1 is reported as conditional (2'b01). In any other state, `in_in_block` has no effect.
- R9: A record with `in_kind` none and `in_wr_pc`=0 gives `out_predict`=0 and `out_class`=2'b00.
- R10: A cycle with `in_valid`=0 gives `out_valid`=0, `out_predict`=0 and `out_class`=2'b00 in the next cycle, whatever the attribute inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An attribute record is present |
| in_kind | input | 2 | Branch kind: 00 none, 01 conditional, 10 unconditional, 11 indirect |
| in_wr_pc | input | 1 | Instruction writes the program counter |
| in_isa_cur | input | 2 | Instruction-set state before the instruction |
| in_isa_next | input | 2 | Instruction-set state after the instruction |
| in_set_flags | input | 1 | Flag-setting suffix present |
| in_mode_chg | input | 1 | Instruction changes processor mode |
| in_in_block | input | 1 | Instruction lies inside a conditional block |
| out_valid | output | 1 | Registered copy of in_valid |
| out_predict | output | 1 | Predictor may act on this instruction |
| out_class | output | 2 | Branch class, same encoding as in_kind |

## Verification
The vector walk gives each branch kind with no attribute set, to separate the plain class mapping from the rules. It then gives each exclusion alone, on branch kinds chosen so that a wrong class and a missing exclusion produce different outputs. Every state pair appears at least once: the wide and narrow pair in both directions, the equal pairs, and switches into the extended and bytecode states. These show whether the state check tests the direction or only tests for a change. Conditional-block records in the narrow, wide and extended states show whether the reclassification is limited to the narrow state. Directed cases then test idle cycles with live attributes and a reset in the middle of the stream.

// File: rtl/bp_elig_filter.sv
module bp_elig_filter (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_kind,
  input  logic       in_wr_pc,
  input  logic [1:0] in_isa_cur,
  input  logic [1:0] in_isa_next,
  input  logic       in_set_flags,
  input  logic       in_mode_chg,
  input  logic       in_in_block,
  output logic       out_valid,
  output logic       out_predict,
  output logic [1:0] out_class
);

  localparam logic [1:0] K_NONE   = 2'b00;
  localparam logic [1:0] K_COND   = 2'b01;
  localparam logic [1:0] K_UNCOND = 2'b10;
  localparam logic [1:0] K_IND    = 2'b11;
  localparam logic [1:0] S_WIDE   = 2'b00;
  localparam logic [1:0] S_NARROW = 2'b01;

  logic       sw_any, sw_ok, excluded, candidate;
  logic [1:0] cls;

  // state switch only tolerated between the wide and narrow sets
  assign sw_any = in_isa_cur != in_isa_next;
  assign sw_ok  = (in_isa_cur == S_WIDE   && in_isa_next == S_NARROW) ||
                  (in_isa_cur == S_NARROW && in_isa_next == S_WIDE);

  assign excluded = in_set_flags | in_mode_chg | (sw_any & ~sw_ok);

  always_comb begin
    cls = in_kind;
    if (in_kind == K_NONE && in_wr_pc)
      cls = K_IND;
    else if (in_kind == K_UNCOND && in_in_block && in_isa_cur == S_NARROW)
      cls = K_COND;
  end

  assign candidate = cls != K_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_predict <= 1'b0;
      out_class   <= K_NONE;
    end else begin
      out_valid   <= in_valid;
      out_predict <= in_valid & candidate & ~excluded;
      out_class   <= in_valid ? cls : K_NONE;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  p_flags_block_r6: assert property (@(posedge clk) disable iff (rst)
    in_set_flags |=> !out_predict);

  p_mode_block_r7: assert property (@(posedge clk) disable iff (rst)
    in_mode_chg |=> !out_predict);

  p_bad_switch_r5: assert property (@(posedge clk) disable iff (rst)
    (in_isa_cur != in_isa_next && in_isa_cur[1] | in_isa_next[1]) |=> !out_predict);

  p_block_recls_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == K_UNCOND && in_in_block && in_isa_cur == S_NARROW)
      |=> out_class == K_COND);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_predict && out_class == K_NONE));

  p_nonbranch_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == K_NONE && !in_wr_pc) |=> (!out_predict && out_class == K_NONE));

  p_pcwrite_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == K_NONE && in_wr_pc) |=> out_class == K_IND);

endmodule

// File: tb/tb_bp_elig_filter.sv
module tb_bp_elig_filter;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_wr_pc, in_set_flags, in_mode_chg, in_in_block;
  logic [1:0] in_kind, in_isa_cur, in_isa_next;
  logic out_valid, out_predict;
  logic [1:0] out_class;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  bp_elig_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_wr_pc(in_wr_pc), .in_isa_cur(in_isa_cur), .in_isa_next(in_isa_next),
    .in_set_flags(in_set_flags), .in_mode_chg(in_mode_chg),
    .in_in_block(in_in_block), .out_valid(out_valid),
    .out_predict(out_predict), .out_class(out_class));

  // {req[3:0], kind[1:0], wr_pc, cur[1:0], nxt[1:0], sf, mc, blk, exp_en, exp_cls[1:0]}
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01}, // R2 cond
    {4'd2, 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10}, // R2 uncond
    {4'd2, 2'b11, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R2 indirect
    {4'd3, 2'b00, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R3 pc write
    {4'd3, 2'b11, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R3 branch also writing pc
    {4'd4, 2'b11, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R4 wide->narrow
    {4'd4, 2'b10, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10}, // R4 narrow->wide
    {4'd4, 2'b11, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R4 no switch
    {4'd5, 2'b11, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11}, // R5 narrow->ext
    {4'd5, 2'b10, 1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10}, // R5 wide->byte
    {4'd5, 2'b01, 1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01}, // R5 ext->narrow
    {4'd6, 2'b11, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11}, // R6 flags
    {4'd6, 2'b00, 1'b1, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11}, // R6 flags pc write
    {4'd7, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01}, // R7 mode change
    {4'd8, 2'b10, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01}, // R8 narrow in block
    {4'd8, 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10}, // R8 wide ignores block
    {4'd8, 2'b10, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10}, // R8 ext ignores block
    {4'd8, 2'b10, 1'b0, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01}, // R8 with R6 exclusion
    {4'd9, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R9 plain op
    {4'd9, 2'b00, 1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00}  // R9 with noise
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [9:0] a);
    in_valid = v;
    {in_kind, in_wr_pc, in_isa_cur, in_isa_next, in_set_flags, in_mode_chg, in_in_block} = a;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 10'b10_0_00_00_000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset predict", out_predict, 0);
    chk("R1 reset class", out_class, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][12:3]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d valid", VEC[i][16:13], i), out_valid, 1);
      chk($sformatf("R%0d vec%0d predict", VEC[i][16:13], i), out_predict, VEC[i][2]);
      chk($sformatf("R%0d vec%0d class", VEC[i][16:13], i), out_class, VEC[i][1:0]);
    end

    // R10: idle cycle with a live branch on the attribute pins
    drive(1'b0, 10'b11_1_00_00_000);
    @(negedge clk);
    chk("R10 idle valid", out_valid, 0);
    chk("R10 idle predict", out_predict, 0);
    chk("R10 idle class", out_class, 0);

    // R1: back-to-back records keep one-cycle latency
    drive(1'b1, 10'b01_0_00_00_000);
    @(negedge clk);
    drive(1'b1, 10'b11_0_00_00_100);
    chk("R1 first of pair class", out_class, 1);
    @(negedge clk);
    chk("R1 second of pair predict", out_predict, 0);
    chk("R1 second of pair class", out_class, 3);

    // R1: reset mid-stream clears outputs on the next edge
    drive(1'b1, 10'b10_0_00_00_000);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset valid", out_valid, 0);
    chk("R1 mid reset predict", out_predict, 0);
    chk("R1 mid reset class", out_class, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset predict", out_predict, 1);
    chk("R2 after reset class", out_class, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule